// File: doc/BRIEF.md
# Pipelined CORDIC Complex Rotator Mixer

This block shifts the spectrum of a sampled signal by turning each incoming complex sample (I, Q) through an angle supplied with it. The angle is an unsigned phase word that normally comes from a free-running phase accumulator: the full word range is one turn, so the most significant bit weighs pi. When the phase word advances by a constant step every sample, the input spectrum moves by the frequency that step represents. A real input is handled by holding Q at zero.

The rotation is done directly on the data vector with shift-and-add CORDIC steps. No sine or cosine is generated and no multipliers are used. The two top phase bits first select a coarse quarter-turn move: a swap of I and Q with a negation, or no move at all. This leaves a residual angle between -pi/2 and +pi/2. Sixteen pipelined micro-rotations of angle atan(2^-k) then drive that residual toward zero. Each step chooses its direction from the sign of the residual. The outputs keep the CORDIC gain of about 1.6468. They are two bits wider than the inputs, so that this gain never overflows.

Top module: `cordic_mixer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_vld` is low and `out_i`/`out_q` are zero. Samples that are in flight when reset arrives never appear at the output.
- R2: A sample accepted with `in_vld` high at a rising edge appears with `out_vld` high exactly ITER+1 rising edges later, counting the capturing edge (17 with defaults). The valid pattern is reproduced unchanged.
- R3: For a valid sample, `out_i` ≈ G·(I·cosθ − Q·sinθ) and `out_q` ≈ G·(I·sinθ + Q·cosθ), within 64 LSB, where G = Π sqrt(1+2^-2k) over k = 0..ITER-1 (≈1.6468). Positive θ turns counter-clockwise.
- R4: θ = 2π·`in_phase`/2^PW, with `in_phase` read as unsigned. Its top bit weighs π, and a word near 2^PW wraps to an angle just below zero.
- R5: All four quarter-turns give correct results, including the exact angles 0, π/2, π and 3π/2. After the coarse move, the residual angle always lies in [−π/2, π/2).
- R6: A nonzero Q input is rotated as a complex value, with both components contributing per R3.
- R7: Full-scale inputs (each component −2^(DW−1) or 2^(DW−1)−1) at any angle give R3-accurate outputs, with no wrap inside the DW+2-bit outputs.
- R8: A cycle with `in_vld` low produces no `out_vld` ITER+1 edges later, whatever its data. It also does not alter valid samples on the cycles next to it.
- R9: Samples may arrive on every clock. A phase that advances by a fixed step per sample gives, back to back, each output rotated by its own phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_i | input | DW | Signed in-phase input |
| in_q | input | DW | Signed quadrature input (zero for a real signal) |
| in_phase | input | PW | Unsigned rotation angle, full range = one turn |
| out_vld | output | 1 | Output sample valid |
| out_i | output | DW+2 | Signed rotated in-phase output, gain ≈1.6468 |
| out_q | output | DW+2 | Signed rotated quadrature output, gain ≈1.6468 |

## Verification
A real tone of fixed amplitude is swept through every sixteenth of a turn, including the exact quarter-turn boundaries. This separates errors in the coarse swap-and-negate move from errors in the fine iterations. Complex inputs with a nonzero Q, full-scale corners and random samples show whether both components are combined with the right signs and whether the guard bits are enough. A stepped phase accumulator fed back to back, and a valid pattern with garbage in the gaps, test the per-sample independence and the valid alignment. A single isolated pulse and a reset in mid-stream pin down the exact latency and the flush of samples in flight.

// File: rtl/cordic_mix_pkg.sv
package cordic_mix_pkg;

    typedef enum logic [1:0] {
        QUAD_0 = 2'b00,   // [0, pi/2)
        QUAD_1 = 2'b01,   // [pi/2, pi)
        QUAD_2 = 2'b10,   // [pi, 3pi/2)
        QUAD_3 = 2'b11    // [3pi/2, 2pi)
    } quad_e;

    localparam real PI_R = 3.14159265358979323846;

    // Elementary angle atan(2^-idx) in phase units, where 2^zw units = one turn.
    function automatic int atan_units(input int idx, input int zw);
        real x;
        real term;
        real ang;
        real scl;
        x = 1.0;
        for (int k = 0; k < idx; k++) x = x / 2.0;
        if (idx == 0) begin
            ang = PI_R / 4.0;
        end else begin
            ang  = 0.0;
            term = x;
            for (int n = 0; n < 40; n++) begin
                ang  = ang + ((n % 2 == 1) ? -1.0 : 1.0) * term / real'(2 * n + 1);
                term = term * x * x;
            end
        end
        scl = 1.0;
        for (int k = 0; k < zw; k++) scl = scl * 2.0;
        return $rtoi(ang * scl / (2.0 * PI_R) + 0.5);
    endfunction

endpackage

// File: rtl/cordic_mix_prerot.sv
module cordic_mix_prerot #(
    parameter int DW    = 16,
    parameter int GUARD = 2,
    parameter int ZW    = 18
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic signed [DW-1:0]         in_i,
    input  logic signed [DW-1:0]         in_q,
    input  logic        [ZW-1:0]         in_phase,
    output logic                         o_vld,
    output logic signed [DW+GUARD-1:0]   o_x,
    output logic signed [DW+GUARD-1:0]   o_y,
    output logic signed [ZW-1:0]         o_z
);
    import cordic_mix_pkg::*;

    localparam int XW = DW + GUARD;
    localparam logic signed [ZW-1:0] QTR = {2'b01, {(ZW-2){1'b0}}};

    quad_e                 quad;
    logic signed [XW-1:0]  xe, ye, nx, ny;
    logic signed [ZW-1:0]  ze, nz;

    always_comb begin
        quad = quad_e'(in_phase[ZW-1 -: 2]);
        xe   = {{GUARD{in_i[DW-1]}}, in_i};
        ye   = {{GUARD{in_q[DW-1]}}, in_q};
        ze   = signed'(in_phase);
        unique case (quad)
            QUAD_0, QUAD_3: begin
                nx = xe;
                ny = ye;
                nz = ze;
            end
            QUAD_1: begin
                nx = -ye;
                ny = xe;
                nz = ze - QTR;
            end
            QUAD_2: begin
                nx = ye;
                ny = -xe;
                nz = ze + QTR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
            o_x   <= '0;
            o_y   <= '0;
            o_z   <= '0;
        end else begin
            o_vld <= in_vld;
            o_x   <= nx;
            o_y   <= ny;
            o_z   <= nz;
        end
    end

endmodule

// File: rtl/cordic_mix_stage.sv
module cordic_mix_stage #(
    parameter int XW    = 18,
    parameter int ZW    = 18,
    parameter int SHIFT = 0,
    parameter int ATAN  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_vld,
    input  logic signed [XW-1:0] i_x,
    input  logic signed [XW-1:0] i_y,
    input  logic signed [ZW-1:0] i_z,
    output logic                 o_vld,
    output logic signed [XW-1:0] o_x,
    output logic signed [XW-1:0] o_y,
    output logic signed [ZW-1:0] o_z
);
    localparam logic signed [ZW-1:0] AK = ZW'(ATAN);

    logic                 neg;
    logic signed [XW-1:0] xs, ys, nx, ny;
    logic signed [ZW-1:0] nz;

    always_comb begin
        neg = i_z[ZW-1];
        xs  = i_x >>> SHIFT;
        ys  = i_y >>> SHIFT;
        if (neg) begin
            nx = i_x + ys;
            ny = i_y - xs;
            nz = i_z + AK;
        end else begin
            nx = i_x - ys;
            ny = i_y + xs;
            nz = i_z - AK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
            o_x   <= '0;
            o_y   <= '0;
            o_z   <= '0;
        end else begin
            o_vld <= i_vld;
            o_x   <= nx;
            o_y   <= ny;
            o_z   <= nz;
        end
    end

endmodule

// File: rtl/cordic_mixer.sv
module cordic_mixer #(
    parameter int DW    = 16,
    parameter int GUARD = 2,
    parameter int ITER  = 16,
    parameter int PW    = 18
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic signed [DW-1:0]       in_i,
    input  logic signed [DW-1:0]       in_q,
    input  logic        [PW-1:0]       in_phase,
    output logic                       out_vld,
    output logic signed [DW+GUARD-1:0] out_i,
    output logic signed [DW+GUARD-1:0] out_q
);
    localparam int XW = DW + GUARD;

    logic                 [ITER:0] v_pipe;
    logic signed [XW-1:0] x_pipe [ITER+1];
    logic signed [XW-1:0] y_pipe [ITER+1];
    logic signed [PW-1:0] z_pipe [ITER+1];

    cordic_mix_prerot #(
        .DW    (DW),
        .GUARD (GUARD),
        .ZW    (PW)
    ) u_prerot (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_i     (in_i),
        .in_q     (in_q),
        .in_phase (in_phase),
        .o_vld    (v_pipe[0]),
        .o_x      (x_pipe[0]),
        .o_y      (y_pipe[0]),
        .o_z      (z_pipe[0])
    );

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        cordic_mix_stage #(
            .XW    (XW),
            .ZW    (PW),
            .SHIFT (g),
            .ATAN  (cordic_mix_pkg::atan_units(g, PW))
        ) u_stg (
            .clk   (clk),
            .rst   (rst),
            .i_vld (v_pipe[g]),
            .i_x   (x_pipe[g]),
            .i_y   (y_pipe[g]),
            .i_z   (z_pipe[g]),
            .o_vld (v_pipe[g+1]),
            .o_x   (x_pipe[g+1]),
            .o_y   (y_pipe[g+1]),
            .o_z   (z_pipe[g+1])
        );
    end

    assign out_vld = v_pipe[ITER];
    assign out_i   = x_pipe[ITER];
    assign out_q   = y_pipe[ITER];

endmodule

// File: rtl/cordic_mixer_chk.sv
module cordic_mixer_chk #(
    parameter int DW    = 16,
    parameter int GUARD = 2,
    parameter int ITER  = 16,
    parameter int PW    = 18
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_vld,
    input logic                       out_vld,
    input logic signed [DW+GUARD-1:0] out_i,
    input logic signed [DW+GUARD-1:0] out_q,
    input logic                       v_first,
    input logic signed [PW-1:0]       z_first,
    input logic                       v_last,
    input logic signed [PW-1:0]       z_last
);
    localparam int LIM  = (2 ** (DW - 1)) * 24 / 10;
    localparam int ZTOL = 2 ** (PW - ITER + 2);

    logic [ITER:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[ITER-1:0], in_vld};
    end

    // R1: reset clears the output stage
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_vld && out_i == '0 && out_q == '0));

    // R2: valid emerges exactly ITER+1 edges after capture
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_vld == sh[ITER]);

    // R5: coarse move leaves residual in [-pi/2, pi/2)
    p_quadrant_r5: assert property (@(posedge clk) disable iff (rst)
        v_first |-> (z_first[PW-1] == z_first[PW-2]));

    // R3: iterations drive the residual angle close to zero
    p_converge_r3: assert property (@(posedge clk) disable iff (rst)
        v_last |-> (z_last <= ZTOL && z_last >= -ZTOL));

    // R7: output magnitude stays inside the gain-bounded range
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_i <= LIM && out_i >= -LIM && out_q <= LIM && out_q >= -LIM));

endmodule

bind cordic_mixer cordic_mixer_chk #(
    .DW    (DW),
    .GUARD (GUARD),
    .ITER  (ITER),
    .PW    (PW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_i   (out_i),
    .out_q   (out_q),
    .v_first (v_pipe[0]),
    .z_first (z_pipe[0]),
    .v_last  (v_pipe[ITER]),
    .z_last  (z_pipe[ITER])
);

// File: tb/cordic_mixer_tb.sv
`timescale 1ns/1ps
module cordic_mixer_tb;
    localparam int  DW    = 16;
    localparam int  GUARD = 2;
    localparam int  ITER  = 16;
    localparam int  PW    = 18;
    localparam int  OW    = DW + GUARD;
    localparam int  LAT   = ITER + 1;
    localparam real TOL   = 64.0;
    localparam real PI_R  = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_vld = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic        [PW-1:0] in_phase = '0;
    logic                 out_vld;
    logic signed [OW-1:0] out_i;
    logic signed [OW-1:0] out_q;

    cordic_mixer #(.DW(DW), .GUARD(GUARD), .ITER(ITER), .PW(PW)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .in_phase(in_phase), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    armed  = 1'b0;
    real   gain;
    string cur_tag = "R1";

    bit    e_v   [LAT];
    real   e_i   [LAT];
    real   e_q   [LAT];
    string e_tag [LAT];

    function automatic real rabs(input real a);
        return (a < 0.0) ? -a : a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
        end
    endtask

    initial begin
        gain = 1.0;
        for (int k = 0; k < ITER; k++) gain = gain * $sqrt(1.0 + 1.0 / real'(4.0 ** k));
    end

    // Behavioural reference: ideal rotation, delayed by LAT edges
    always @(posedge clk) begin
        real th;
        if (rst) begin
            for (int k = 0; k < LAT; k++) e_v[k] = 1'b0;
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                e_v[k]   = e_v[k-1];
                e_i[k]   = e_i[k-1];
                e_q[k]   = e_q[k-1];
                e_tag[k] = e_tag[k-1];
            end
            th       = real'(in_phase) / real'(2.0 ** PW) * 2.0 * PI_R;
            e_v[0]   = in_vld;
            e_i[0]   = gain * (real'(in_i) * $cos(th) - real'(in_q) * $sin(th));
            e_q[0]   = gain * (real'(in_i) * $sin(th) + real'(in_q) * $cos(th));
            e_tag[0] = cur_tag;
        end
    end

    always @(negedge clk) begin
        if (!rst && armed) begin
            chk(out_vld == e_v[LAT-1], e_tag[LAT-1], "valid", real'(out_vld), real'(e_v[LAT-1]));
            if (out_vld && e_v[LAT-1]) begin
                chk(rabs(real'(out_i) - e_i[LAT-1]) <= TOL, e_tag[LAT-1], "out_i", real'(out_i), e_i[LAT-1]);
                chk(rabs(real'(out_q) - e_q[LAT-1]) <= TOL, e_tag[LAT-1], "out_q", real'(out_q), e_q[LAT-1]);
            end
        end
    end

    task automatic send(input bit v, input int xi, input int xq, input int ph, input string tag);
        @(negedge clk);
        in_vld   = v;
        in_i     = DW'(xi);
        in_q     = DW'(xq);
        in_phase = PW'(ph);
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send(1'b0, 0, 0, 0, cur_tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat;
        int acc;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(out_vld == 1'b0, "R1", "reset out_vld", real'(out_vld), 0.0);
        chk(out_i == '0,     "R1", "reset out_i",   real'(out_i), 0.0);
        chk(out_q == '0,     "R1", "reset out_q",   real'(out_q), 0.0);
        rst   = 1'b0;
        armed = 1'b1;
        idle(3);

        // R2: isolated pulse latency
        send(1'b1, 12000, 0, 0, "R2");
        lat = -1;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            in_vld = 1'b0;
            if (out_vld) begin
                lat = n;
                break;
            end
        end
        chk(lat == LAT, "R2", "latency", real'(lat), real'(LAT));
        idle(LAT + 2);

        // R5: every sixteenth of a turn, exact quarter-turns included
        for (int k = 0; k < 16; k++) send(1'b1, 20000, 0, k * (2 ** (PW - 4)), "R5");
        // R4: unsigned scaling and wrap near full scale
        send(1'b1, 18000, 0, (2 ** PW) / 6, "R4");
        send(1'b1, 18000, 0, (2 ** PW) / 3, "R4");
        send(1'b1, 18000, 0, (2 ** PW) - 1, "R4");
        send(1'b1, 18000, 0, (2 ** (PW - 1)) + 1, "R4");
        // R6: complex input
        for (int k = 0; k < 8; k++) send(1'b1, 10000, -15000, k * 33000 + 777, "R6");
        for (int k = 0; k < 4; k++) send(1'b1, 0, 25000, k * 65536 + 12345, "R6");
        // R7: full-scale corners
        for (int k = 0; k < 8; k++) begin
            send(1'b1, -32768, -32768, k * (2 ** (PW - 3)) + (2 ** (PW - 4)), "R7");
            send(1'b1, 32767, -32768, k * (2 ** (PW - 3)), "R7");
        end
        // R8: gaps carrying garbage
        for (int k = 0; k < 20; k++) begin
            if (k % 2 == 0) send(1'b1, 9000 + k * 100, -4000, k * 9001, "R8");
            else            send(1'b0, -32768, 32767, 131071, "R8");
        end
        // R9: back-to-back stepped phase accumulator
        acc = 0;
        for (int k = 0; k < 200; k++) begin
            send(1'b1, 15000, 3000, acc, "R9");
            acc = (acc + 5311) % (2 ** PW);
        end
        // R3: random samples and angles
        for (int k = 0; k < 300; k++) send(1'b1, int'($urandom), int'($urandom), int'($urandom), "R3");
        idle(LAT + 3);

        // R1: reset in mid-stream flushes samples in flight
        for (int k = 0; k < 6; k++) send(1'b1, 20000, 5000, k * 4000, "R1");
        @(negedge clk);
        in_vld = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1", "mid reset out_vld", real'(out_vld), 0.0);
        chk(out_i == '0,     "R1", "mid reset out_i",   real'(out_i), 0.0);
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < LAT + 4; n++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R1", "flushed out_vld", real'(out_vld), 0.0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule